// File: doc/BRIEF.md
# Bit Clock and Frame Pulse Generator

This block derives the bit clock and the frame pulse for a synchronous serial audio port from a single reference clock. A counter divides the reference clock by a programmable amount to make the bit clock. Alongside the bit clock it raises a one-cycle strobe in the reference domain, which marks each rising edge of the bit clock for downstream shift logic. A second counter walks through the bit positions of a frame and holds the frame pulse active for a programmable number of leading bit clocks. Divisor, frame length and pulse length all use "field value plus one" encoding.

Two run controls are kept apart: `gen_run` starts the clock divider and `fs_run` releases the frame pulse. The clock can therefore run toward the far end while frame pulses are still held off. Select inputs choose between the generated bit clock and an external clock pin, and between the generated frame pulse and an external frame pin. Separate polarity bits act on the clock and on the frame pulse at the outputs.

The divider has two states: `DIV_STOP`, which it leaves when `gen_run` is set, and `DIV_RUN`, to which it returns from `DIV_STOP` and which it leaves when `gen_run` clears. The frame sequencer has three states. `FRM_OFF` moves to `FRM_PULSE` on the first bit strobe after release. `FRM_PULSE` moves to `FRM_GAP` once the pulse length is used up. Both `FRM_PULSE` and `FRM_GAP` return to `FRM_PULSE` at the frame boundary. Any state falls back to `FRM_OFF` when the frame is disabled. The divisor, frame length and pulse length are copied into shadow registers only while the sequencer sits in `FRM_OFF` or at a frame boundary.

Top module: `srfs_gen`

## Requirements
- R1: With `clk_int_sel`=1 and divisor field D, `bclk_stb` is high for one reference cycle every D+1 cycles, and the generated bit clock is high for floor(D/2)+1 cycles, starting with the strobe cycle.
- R2: With D=0 the strobe is high on every reference cycle and the generated bit clock is the reference clock itself.
- R3: With frame field P the frame pulse repeats every (P+1) bit clocks.
- R4: With width field W and W<P, the pulse is active for (W+1) bit clocks at the start of each frame. With W>=P it stays active without a break.
- R5: While `gen_run` is 0 and the internal clock is selected, no strobe appears, the generated bit clock is low before polarity, and the frame pulse is inactive. This is also the state after reset.
- R6: While `fs_run` is 0 the strobe keeps running but the frame pulse stays inactive.
- R7: After `fs_run` is set with the clock running, the first pulse begins on the first bit strobe, within D+1 reference cycles. The bit counter starts at zero.
- R8: `fs_pol`=0 makes `fsync` active high, and `fs_pol`=1 makes it active low.
- R9: `bclk_pol`=1 drives `bclk` at the generated level, so its rising edge coincides with the strobe and receive data is taken on the rising edge. `bclk_pol`=0 drives the inverted level.
- R10: With `fs_int_sel`=0, `fsync` equals `ext_fs` XOR `fs_pol` without any clock delay.
- R11: With `clk_int_sel`=0, `bclk` follows `ext_bclk` (XOR the inverse of `bclk_pol`). There is one strobe per rising edge of `ext_bclk` after a two-stage synchronizer, and frames count those strobes even while `gen_run` is 0.
- R12: A change of D, P or W made during a frame takes effect from the next frame boundary. The current frame completes with the old values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gen_run | input | 1 | 1 runs the clock divider, 0 holds it stopped |
| fs_run | input | 1 | 1 releases the frame pulse, 0 holds it inactive |
| div_cfg | input | 8 | Divisor field D, bit clock = reference / (D+1) |
| per_cfg | input | 12 | Frame field P, frame = P+1 bit clocks |
| wid_cfg | input | 8 | Width field W, pulse = W+1 bit clocks |
| clk_int_sel | input | 1 | 1 selects the generated bit clock, 0 selects ext_bclk |
| fs_int_sel | input | 1 | 1 selects the generated pulse, 0 selects ext_fs |
| bclk_pol | input | 1 | Bit clock polarity, 1 passes the level, 0 inverts it |
| fs_pol | input | 1 | Frame polarity, 0 active high, 1 active low |
| ext_bclk | input | 1 | External bit clock pin |
| ext_fs | input | 1 | External frame pin |
| bclk | output | 1 | Bit clock to the port |
| bclk_stb | output | 1 | One-cycle marker of each bit clock rising edge |
| fsync | output | 1 | Frame pulse to the port |

## Verification
A divider count that wraps at the wrong value shows up within one bit period as strobe spacing different from D+1 cycles, and as a wrong high time on the bit clock. A bit counter or sequencer state that slips shows up at the ports within one frame, as a pulse length or frame length that is not a whole multiple of the expected bit period. A shadow register loaded at the wrong moment shows up in the very frame in which the fields are changed, because that frame then ends early or late. The bench sweeps small divisors, frame lengths and widths and computes each expected count arithmetically.

// File: rtl/srfs_pkg.sv
package srfs_pkg;

    // clock divider control states
    typedef enum logic {
        DIV_STOP,
        DIV_RUN
    } div_state_t;

    // frame sequencer states
    typedef enum logic [1:0] {
        FRM_OFF,
        FRM_PULSE,
        FRM_GAP
    } frm_state_t;

endpackage

// File: rtl/srfs_clkdiv.sv
module srfs_clkdiv
    import srfs_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div_val,
    output logic             stb,
    output logic             phase,
    output logic             running
);

    div_state_t       state_q, state_d;
    logic [DIV_W-1:0] cnt_q, cnt_d;

    // next state and count
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            DIV_STOP: begin
                cnt_d = '0;
                if (run) state_d = DIV_RUN;
            end
            DIV_RUN: begin
                if (!run) begin
                    state_d = DIV_STOP;
                    cnt_d   = '0;
                end else if (cnt_q >= div_val) begin
                    cnt_d = '0;
                end else begin
                    cnt_d = cnt_q + DIV_W'(1);
                end
            end
            default: begin
                state_d = DIV_STOP;
                cnt_d   = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= DIV_STOP;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // outputs
    always_comb begin
        running = (state_q == DIV_RUN);
        stb     = running && (cnt_q == '0);
        phase   = running && (cnt_q <= (div_val >> 1));
    end

endmodule

// File: rtl/srfs_edge_sync.sv
module srfs_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);

    logic [STAGES:0] sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[STAGES-1:0], din};
        end
    end

    assign rise = sync_q[STAGES-1] & ~sync_q[STAGES];

endmodule

// File: rtl/srfs_frame.sv
module srfs_frame
    import srfs_pkg::*;
#(
    parameter int DIV_W = 8,
    parameter int PER_W = 12,
    parameter int WID_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             stb,
    input  logic [DIV_W-1:0] div_cfg,
    input  logic [PER_W-1:0] per_cfg,
    input  logic [WID_W-1:0] wid_cfg,
    output logic [DIV_W-1:0] div_sh,
    output logic [PER_W-1:0] per_sh,
    output logic             fs_gen,
    output logic             in_frame,
    output logic [PER_W-1:0] bit_cnt
);

    frm_state_t       state_q, state_d;
    logic [PER_W-1:0] cnt_q, cnt_d, nxt;
    logic [WID_W-1:0] wid_q;
    logic [DIV_W-1:0] div_q;
    logic [PER_W-1:0] per_q;
    logic             boundary;
    logic             load;

    // next state, bit index and boundary detection
    always_comb begin
        state_d  = state_q;
        cnt_d    = cnt_q;
        boundary = 1'b0;
        nxt      = cnt_q + PER_W'(1);
        if (!en) begin
            state_d = FRM_OFF;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                FRM_OFF: begin
                    if (stb) begin
                        state_d = FRM_PULSE;
                        cnt_d   = '0;
                    end
                end
                FRM_PULSE, FRM_GAP: begin
                    if (stb) begin
                        if (cnt_q >= per_q) begin
                            boundary = 1'b1;
                            state_d  = FRM_PULSE;
                            cnt_d    = '0;
                        end else begin
                            cnt_d   = nxt;
                            state_d = (nxt <= PER_W'(wid_q)) ? FRM_PULSE : FRM_GAP;
                        end
                    end
                end
                default: begin
                    state_d = FRM_OFF;
                    cnt_d   = '0;
                end
            endcase
        end
        load = (state_q == FRM_OFF) || boundary;
    end

    // state and shadow registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FRM_OFF;
            cnt_q   <= '0;
            div_q   <= '0;
            per_q   <= '0;
            wid_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            if (load) begin
                div_q <= div_cfg;
                per_q <= per_cfg;
                wid_q <= wid_cfg;
            end
        end
    end

    // outputs
    always_comb begin
        fs_gen   = (state_q == FRM_PULSE);
        in_frame = (state_q != FRM_OFF);
        bit_cnt  = cnt_q;
        div_sh   = div_q;
        per_sh   = per_q;
    end

endmodule

// File: rtl/srfs_gen.sv
module srfs_gen #(
    parameter int DIV_W       = 8,
    parameter int PER_W       = 12,
    parameter int WID_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gen_run,
    input  logic             fs_run,
    input  logic [DIV_W-1:0] div_cfg,
    input  logic [PER_W-1:0] per_cfg,
    input  logic [WID_W-1:0] wid_cfg,
    input  logic             clk_int_sel,
    input  logic             fs_int_sel,
    input  logic             bclk_pol,
    input  logic             fs_pol,
    input  logic             ext_bclk,
    input  logic             ext_fs,
    output logic             bclk,
    output logic             bclk_stb,
    output logic             fsync
);

    logic [DIV_W-1:0] div_sh;
    logic [PER_W-1:0] per_sh;
    logic [PER_W-1:0] bit_cnt;
    logic             div_stb, div_phase, div_running;
    logic             ext_stb, sel_stb;
    logic             frm_en, fs_gen, in_frame;
    logic             gen_lvl, clk_lvl, fs_lvl;

    srfs_clkdiv #(.DIV_W(DIV_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (gen_run),
        .div_val (div_sh),
        .stb     (div_stb),
        .phase   (div_phase),
        .running (div_running)
    );

    srfs_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (ext_bclk),
        .rise  (ext_stb)
    );

    assign sel_stb = clk_int_sel ? div_stb : ext_stb;
    assign frm_en  = fs_run && (gen_run || !clk_int_sel);

    srfs_frame #(.DIV_W(DIV_W), .PER_W(PER_W), .WID_W(WID_W)) u_frm (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (frm_en),
        .stb      (sel_stb),
        .div_cfg  (div_cfg),
        .per_cfg  (per_cfg),
        .wid_cfg  (wid_cfg),
        .div_sh   (div_sh),
        .per_sh   (per_sh),
        .fs_gen   (fs_gen),
        .in_frame (in_frame),
        .bit_cnt  (bit_cnt)
    );

    // a zero divisor hands the reference clock straight through
    always_comb begin
        gen_lvl  = (div_running && (div_sh == '0)) ? clk : div_phase;
        clk_lvl  = clk_int_sel ? gen_lvl : ext_bclk;
        fs_lvl   = fs_int_sel ? fs_gen : ext_fs;
        bclk     = bclk_pol ? clk_lvl : ~clk_lvl;
        bclk_stb = sel_stb;
        fsync    = fs_lvl ^ fs_pol;
    end

endmodule

// File: rtl/srfs_gen_chk.sv
module srfs_gen_chk #(
    parameter int DIV_W = 8,
    parameter int PER_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             gen_run,
    input logic             fs_run,
    input logic             div_stb,
    input logic [DIV_W-1:0] div_sh,
    input logic             sel_stb,
    input logic             fs_gen,
    input logic             in_frame,
    input logic [PER_W-1:0] bit_cnt,
    input logic [PER_W-1:0] per_sh
);

    // R5
    div_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !gen_run |=> !div_stb);

    // R1
    stb_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (div_stb && (div_sh != '0)) |=> !div_stb);

    // R6
    frame_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fs_run |=> !fs_gen);

    // R7
    pulse_on_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fs_gen) |-> $past(sel_stb));

    // R3
    no_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_frame |-> (bit_cnt <= per_sh));

endmodule

bind srfs_gen srfs_gen_chk #(.DIV_W(DIV_W), .PER_W(PER_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .gen_run  (gen_run),
    .fs_run   (fs_run),
    .div_stb  (div_stb),
    .div_sh   (div_sh),
    .sel_stb  (sel_stb),
    .fs_gen   (fs_gen),
    .in_frame (in_frame),
    .bit_cnt  (bit_cnt),
    .per_sh   (per_sh)
);

// File: tb/sim_srfs_gen.sv
`timescale 1ns/1ps
module sim_srfs_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        gen_run = 1'b0;
    logic        fs_run = 1'b0;
    logic [7:0]  div_cfg = '0;
    logic [11:0] per_cfg = '0;
    logic [7:0]  wid_cfg = '0;
    logic        clk_int_sel = 1'b1;
    logic        fs_int_sel = 1'b1;
    logic        bclk_pol = 1'b1;
    logic        fs_pol = 1'b0;
    logic        ext_bclk = 1'b0;
    logic        ext_fs = 1'b0;
    logic        ext_run = 1'b0;
    int          ext_ph = 0;
    logic        bclk, bclk_stb, fsync;

    int n_chk = 0;
    int n_err = 0;

    always #2 clk = ~clk;

    srfs_gen u0 (
        .clk(clk), .rst_n(rst_n), .gen_run(gen_run), .fs_run(fs_run),
        .div_cfg(div_cfg), .per_cfg(per_cfg), .wid_cfg(wid_cfg),
        .clk_int_sel(clk_int_sel), .fs_int_sel(fs_int_sel),
        .bclk_pol(bclk_pol), .fs_pol(fs_pol),
        .ext_bclk(ext_bclk), .ext_fs(ext_fs),
        .bclk(bclk), .bclk_stb(bclk_stb), .fsync(fsync)
    );

    // external bit clock: toggles every third reference cycle, period 6
    always begin
        @(posedge clk);
        #2;
        if (ext_run) begin
            if (ext_ph == 2) begin
                ext_ph   = 0;
                ext_bclk = ~ext_bclk;
            end else begin
                ext_ph++;
            end
        end
    end

    function automatic logic act();
        return fsync ^ fs_pol;
    endfunction

    task automatic chk(input string req, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_err++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic restart(input int d, input int p, input int w);
        gen_run = 1'b0;
        fs_run  = 1'b0;
        step();
        step();
        div_cfg = 8'(d);
        per_cfg = 12'(p);
        wid_cfg = 8'(w);
        gen_run = 1'b1;
        fs_run  = 1'b1;
    endtask

    task automatic next_rise(input string req, output int n);
        logic prev;
        bit   found;
        prev  = act();
        found = 0;
        n     = 0;
        for (int i = 0; i < 4000; i++) begin
            step();
            n++;
            if (!prev && act()) begin
                found = 1;
                break;
            end
            prev = act();
        end
        if (!found) chk({req, " timeout"}, 0, 1);
    endtask

    // called on the sample where the pulse has just become active
    task automatic measure(output int hi, output int per);
        logic prev;
        hi   = 1;
        per  = 1;
        prev = 1'b1;
        for (int i = 0; i < 4000; i++) begin
            step();
            if (!prev && act()) break;
            per++;
            if (act()) hi++;
            prev = act();
        end
    endtask

    task automatic stb_gap(output int gap, output int hib);
        for (int i = 0; i < 4000; i++) begin
            if (bclk_stb) break;
            step();
        end
        gap = 1;
        hib = bclk ? 1 : 0;
        for (int i = 0; i < 4000; i++) begin
            step();
            if (bclk_stb) break;
            gap++;
            hib += bclk ? 1 : 0;
        end
    endtask

    initial begin
        #600000;
        n_err++;
        n_chk++;
        $display("FAIL watchdog: got 0 expected 1");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        int n, hi, per, gap, hib, stb_seen;
        int plist [3] = '{1, 2, 4};

        // reset state (R5)
        step(); step(); step();
        chk("R5 reset stb", int'(bclk_stb), 0);
        chk("R5 reset bclk", int'(bclk), 0);
        chk("R5 reset fsync", int'(fsync), 0);
        rst_n = 1'b1;
        step();

        // sweep divisor, frame and width (R1 R3 R4)
        for (int d = 0; d < 4; d++) begin
            for (int pi = 0; pi < 3; pi++) begin
                for (int wi = 0; wi < 2; wi++) begin
                    int p = plist[pi];
                    int w = (wi == 0) ? 0 : p - 1;
                    restart(d, p, w);
                    next_rise("R3", n);
                    measure(hi, per);
                    chk($sformatf("R4 width d%0d p%0d w%0d", d, p, w), hi, (w + 1) * (d + 1));
                    chk($sformatf("R3 period d%0d p%0d w%0d", d, p, w), per, (p + 1) * (d + 1));
                    stb_gap(gap, hib);
                    chk($sformatf("R1 strobe gap d%0d", d), gap, d + 1);
                    chk($sformatf("R1 bclk high d%0d", d), hib, d / 2 + 1);
                end
            end
        end

        // width not below frame length: pulse never drops (R4)
        restart(1, 2, 2);
        next_rise("R4", n);
        hi = 0;
        for (int i = 0; i < 30; i++) begin
            hi += act() ? 1 : 0;
            step();
        end
        chk("R4 continuous pulse", hi, 30);

        // zero divisor (R2)
        restart(0, 3, 0);
        step();
        stb_seen = 0;
        for (int i = 0; i < 8; i++) begin
            stb_seen += bclk_stb ? 1 : 0;
            step();
        end
        chk("R2 strobe every cycle", stb_seen, 8);
        chk("R2 bclk high with clk", int'(bclk), 1);
        @(negedge clk);
        #1;
        chk("R2 bclk low with clk", int'(bclk), 0);
        step();

        // generator stopped (R5)
        div_cfg = 8'd1;
        gen_run = 1'b0;
        step(); step();
        stb_seen = 0;
        hi = 0;
        n = 0;
        for (int i = 0; i < 10; i++) begin
            stb_seen += bclk_stb ? 1 : 0;
            hi += bclk ? 1 : 0;
            n += act() ? 1 : 0;
            step();
        end
        chk("R5 no strobe", stb_seen, 0);
        chk("R5 bclk low", hi, 0);
        chk("R5 fsync idle", n, 0);

        // frame held, clock running, then first pulse latency (R6 R7)
        fs_run  = 1'b0;
        div_cfg = 8'd3;
        per_cfg = 12'd3;
        wid_cfg = 8'd0;
        gen_run = 1'b1;
        stb_seen = 0;
        n = 0;
        for (int i = 0; i < 12; i++) begin
            step();
            stb_seen += bclk_stb ? 1 : 0;
            n += act() ? 1 : 0;
        end
        chk("R6 strobes while held", stb_seen, 3);
        chk("R6 pulse held", n, 0);
        fs_run = 1'b1;
        n = 0;
        for (int i = 0; i < 20; i++) begin
            step();
            n++;
            if (act()) break;
        end
        chk("R7 first pulse in range", int'(n >= 1 && n <= 4), 1);

        // change at frame boundary (R12)
        restart(1, 3, 0);
        next_rise("R12", n);
        per_cfg = 12'd5;
        next_rise("R12", n);
        chk("R12 current frame old length", n, 8);
        next_rise("R12", n);
        chk("R12 next frame new length", n, 12);

        // active-low frame pulse (R8)
        fs_pol = 1'b1;
        gen_run = 1'b0;
        fs_run = 1'b0;
        step();
        chk("R8 idle level high", int'(fsync), 1);
        restart(1, 3, 1);
        next_rise("R8", n);
        chk("R8 active level low", int'(fsync), 0);
        measure(hi, per);
        chk("R8 width", hi, 4);
        chk("R8 period", per, 8);
        fs_pol = 1'b0;

        // bit clock polarity (R9)
        bclk_pol = 1'b0;
        gen_run  = 1'b0;
        step(); step();
        chk("R9 stopped inverted", int'(bclk), 1);
        restart(3, 3, 0);
        stb_gap(gap, hib);
        chk("R9 strobe gap", gap, 4);
        chk("R9 inverted high time", hib, 2);
        bclk_pol = 1'b1;

        // external frame pin (R10)
        fs_int_sel = 1'b0;
        ext_fs = 1'b1;
        #0.5;
        chk("R10 ext high", int'(fsync), 1);
        ext_fs = 1'b0;
        #0.5;
        chk("R10 ext low", int'(fsync), 0);
        fs_pol = 1'b1;
        #0.5;
        chk("R10 ext low inverted", int'(fsync), 1);
        fs_pol = 1'b0;
        fs_int_sel = 1'b1;
        step();

        // external bit clock (R11)
        gen_run = 1'b0;
        fs_run = 1'b0;
        clk_int_sel = 1'b0;
        ext_run = 1'b1;
        per_cfg = 12'd2;
        wid_cfg = 8'd0;
        step(); step();
        chk("R11 bclk follows pin", int'(bclk), int'(ext_bclk));
        fs_run = 1'b1;
        next_rise("R11", n);
        measure(hi, per);
        chk("R11 width", hi, 6);
        chk("R11 period", per, 18);
        stb_gap(gap, hib);
        chk("R11 strobe gap", gap, 6);
        ext_run = 1'b0;

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule